// File: doc/BRIEF.md
# SPI Master Register and FIFO Front-End

This block is the bus-facing half of an SPI master. A 32-bit register bus with byte offsets reaches a set of configuration registers: enable, clock divider and clock edge controls, transmit and receive word setup, frame signal setup and FIFO thresholds. Their fields drive the serial frame engine directly. The block also holds an eight-entry transmit FIFO and an eight-entry receive FIFO, a status word, sticky interrupt flags and an interrupt line.

One data offset serves both directions. A write to it queues a word for transmission, and a read from it takes the oldest received word. The serial engine is a separate block. It pulls transmit words through a valid/ready handshake and delivers each received word as a one-cycle strobe. It also reports whether it is busy and when a transmit has completed.

The read data path is combinational, so `bus_rdata` is valid in the same cycle as the request. Any side effect of a read or a write takes place at the clock edge that ends that cycle.

Top module: `spi_regfile`

## Requirements
- R1: After reset, every configuration field and threshold is 0. The status word (offset 0x14) reads 0x00000020, and `tx_valid` and `irq` are low.
- R2: Each configuration register reads back only its implemented bits, and those bits drive their matching output fields. After writing all ones, the reads are: 0x00 → 0x1, 0x04 → 0x70FF (divider in bits 7:0), 0x08 → 0x3FFF, 0x0C → 0xFF, 0x10 → 0xC000, 0x18 → 0x19 and 0x20 → 0x0F0F.
- R3: A write to offset 0x24 queues the word in the transmit FIFO. `tx_valid` is high only while the enable (offset 0x00, bit 0) is 1 and the FIFO holds data. Words leave in write order, one per cycle in which `tx_valid` and `tx_ready` are both high.
- R4: The transmit FIFO holds 8 words. Status bit 5 is 1 while it is not full. A write to the data offset while it is full is dropped.
- R5: A read of offset 0x24 returns and removes the oldest received word. When the receive FIFO is empty, the read returns 0 and changes nothing.
- R6: Status bit 0 is 1 while the receive FIFO holds data. Status bit 7 follows `eng_busy`.
- R7: A write to offset 0x20 with bit 12 set empties the transmit FIFO, and with bit 4 set empties the receive FIFO. The same write stores the thresholds (bits 11:8 and 3:0). Bits 12 and 4 always read as 0.
- R8: A received word that arrives while the receive FIFO holds 8 words is discarded and sets the overrun flag (bit 0 at offset 0x1C).
- R9: Every accepted received word sets flag bit 3, and an `eng_tx_done` pulse sets flag bit 4. Writing a 1 to a bit at offset 0x1C clears that flag, and writing 0 has no effect. When a flag is set and cleared in the same cycle, the set wins. Reads of 0x1C return the flags.
- R10: `irq` is high exactly when some flag is set and its enable bit at offset 0x18 (bits 4, 3 and 0) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cfg_enable | output | 1 | Engine enable |
| cfg_clk_div | output | 8 | Serial clock divider |
| cfg_capture_fall | output | 1 | Capture edge select |
| cfg_idle_high | output | 1 | Clock idle level |
| cfg_clk_delay | output | 1 | Clock delay select |
| cfg_frame_pol | output | 1 | Frame signal polarity |
| cfg_frame_edge | output | 1 | Frame start edge |
| cfg_tx_wlen | output | 6 | Transmit word length |
| cfg_tx_fmt | output | 2 | Transmit bit order/format |
| cfg_tx_dlen | output | 6 | Transmit data length |
| cfg_rx_fmt | output | 2 | Receive bit order/format |
| cfg_rx_dlen | output | 6 | Receive data length |
| cfg_tx_thr | output | 4 | Transmit FIFO threshold |
| cfg_rx_thr | output | 4 | Receive FIFO threshold |
| eng_busy | input | 1 | Engine is shifting |
| eng_tx_done | input | 1 | Transmit-complete pulse |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | Engine takes the transmit word |
| tx_word | output | 32 | Head of the transmit FIFO |
| rx_valid | input | 1 | Received word strobe |
| rx_word | input | 32 | Received word |
| irq | output | 1 | Interrupt request |

## Verification
A wrong FIFO count or pointer shows up at the first data read or engine pop after the fault. Depending on the fault, that read returns a word out of order, a stale word or a non-zero value from an empty FIFO. A wrong count also shows in status bits 5 and 0 in the very next cycle. A flag that is wrong, or that clears when it should not, appears on the next read of 0x1C and through `irq` one cycle after the event. The bench therefore fills the FIFOs to their limits, reads past empty and sends clears that collide with flag sets.

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cfg_enable,
  output logic [7:0]        cfg_clk_div,
  output logic              cfg_capture_fall,
  output logic              cfg_idle_high,
  output logic              cfg_clk_delay,
  output logic              cfg_frame_pol,
  output logic              cfg_frame_edge,
  output logic [5:0]        cfg_tx_wlen,
  output logic [1:0]        cfg_tx_fmt,
  output logic [5:0]        cfg_tx_dlen,
  output logic [1:0]        cfg_rx_fmt,
  output logic [5:0]        cfg_rx_dlen,
  output logic [3:0]        cfg_tx_thr,
  output logic [3:0]        cfg_rx_thr,
  input  logic              eng_busy,
  input  logic              eng_tx_done,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_word,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  output logic              irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [4:0] FLAG_MASK = 5'b11001;

  localparam logic [5:0] A_CTL = 6'h00, A_CLK = 6'h04, A_TXW = 6'h08, A_RXW = 6'h0C,
                         A_FRM = 6'h10, A_STS = 6'h14, A_IEN = 6'h18, A_ICL = 6'h1C,
                         A_FIF = 6'h20, A_DAT = 6'h24;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire wr_en = bus_sel & bus_wr;
  wire rd_en = bus_sel & ~bus_wr;

  logic [4:0] ien_q, flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_enable <= 1'b0; cfg_clk_div <= '0;
      cfg_capture_fall <= 1'b0; cfg_idle_high <= 1'b0; cfg_clk_delay <= 1'b0;
      cfg_frame_pol <= 1'b0; cfg_frame_edge <= 1'b0;
      cfg_tx_wlen <= '0; cfg_tx_fmt <= '0; cfg_tx_dlen <= '0;
      cfg_rx_fmt <= '0; cfg_rx_dlen <= '0;
      cfg_tx_thr <= '0; cfg_rx_thr <= '0;
      ien_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_CTL: cfg_enable <= bus_wdata[0];
        A_CLK: begin
          cfg_capture_fall <= bus_wdata[14];
          cfg_idle_high    <= bus_wdata[13];
          cfg_clk_delay    <= bus_wdata[12];
          cfg_clk_div      <= bus_wdata[7:0];
        end
        A_TXW: begin
          cfg_tx_wlen <= bus_wdata[13:8];
          cfg_tx_fmt  <= bus_wdata[7:6];
          cfg_tx_dlen <= bus_wdata[5:0];
        end
        A_RXW: begin
          cfg_rx_fmt  <= bus_wdata[7:6];
          cfg_rx_dlen <= bus_wdata[5:0];
        end
        A_FRM: begin
          cfg_frame_pol  <= bus_wdata[15];
          cfg_frame_edge <= bus_wdata[14];
        end
        A_IEN: ien_q <= bus_wdata[4:0] & FLAG_MASK;
        A_FIF: begin
          cfg_tx_thr <= bus_wdata[11:8];
          cfg_rx_thr <= bus_wdata[3:0];
        end
        default: ;
      endcase
    end
  end

  // transmit FIFO
  logic [WORD_W-1:0] tx_mem [DEPTH];
  logic [PW-1:0]     tx_wp, tx_rp;
  logic [CW-1:0]     tx_cnt;
  wire tx_flush = wr_en && bus_addr == A_FIF && bus_wdata[12];
  wire tx_push  = wr_en && bus_addr == A_DAT && tx_cnt != FULL;
  wire tx_pop   = tx_valid && tx_ready;

  assign tx_valid = cfg_enable && tx_cnt != '0;
  assign tx_word  = tx_mem[tx_rp];

  always_ff @(posedge clk) if (tx_push) tx_mem[tx_wp] <= bus_wdata[WORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      case ({tx_push, tx_pop})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // receive FIFO
  logic [WORD_W-1:0] rx_mem [DEPTH];
  logic [PW-1:0]     rx_wp, rx_rp;
  logic [CW-1:0]     rx_cnt;
  wire rx_flush = wr_en && bus_addr == A_FIF && bus_wdata[4];
  wire rx_push  = rx_valid && rx_cnt != FULL;
  wire rx_ovr   = rx_valid && rx_cnt == FULL;
  wire rx_pop   = rd_en && bus_addr == A_DAT && rx_cnt != '0;

  always_ff @(posedge clk) if (rx_push) rx_mem[rx_wp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      case ({rx_push, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // sticky flags, set wins over clear
  wire [4:0] flg_set = {eng_tx_done, rx_push, 2'b00, rx_ovr};
  wire [4:0] flg_clr = (wr_en && bus_addr == A_ICL) ? (bus_wdata[4:0] & FLAG_MASK) : 5'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= (flg_q & ~flg_clr) | flg_set;
  end

  assign irq = |(flg_q & ien_q);

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = {31'b0, cfg_enable};
      A_CLK:   bus_rdata = {17'b0, cfg_capture_fall, cfg_idle_high, cfg_clk_delay, 4'b0, cfg_clk_div};
      A_TXW:   bus_rdata = {18'b0, cfg_tx_wlen, cfg_tx_fmt, cfg_tx_dlen};
      A_RXW:   bus_rdata = {24'b0, cfg_rx_fmt, cfg_rx_dlen};
      A_FRM:   bus_rdata = {16'b0, cfg_frame_pol, cfg_frame_edge, 14'b0};
      A_STS:   bus_rdata = {24'b0, eng_busy, 1'b0, tx_cnt != FULL, 4'b0, rx_cnt != '0};
      A_IEN:   bus_rdata = {27'b0, ien_q};
      A_ICL:   bus_rdata = {27'b0, flg_q};
      A_FIF:   bus_rdata = {20'b0, cfg_tx_thr, 4'b0, cfg_rx_thr};
      A_DAT:   bus_rdata = (rx_cnt != '0) ? 32'(rx_mem[rx_rp]) : 32'b0;
      default: bus_rdata = 32'b0;
    endcase
  end

  p_tx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL);
  p_rx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL);
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !tx_flush && !(wr_en && bus_addr == A_CTL) |=> tx_valid && $stable(tx_word));
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> !tx_valid && bus_rdata != 32'hFFFF_FFFF);
  p_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n) rx_ovr |=> flg_q[0]);
  p_empty_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && bus_addr == A_DAT && rx_cnt == '0 && !rx_valid |=> rx_cnt == '0);
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && bus_addr == A_ICL && bus_wdata[3] && !rx_valid |=> !flg_q[3]);
endmodule

// File: tb/tb_spi_regfile.sv
`timescale 1ns/1ps
module tb_spi_regfile;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cfg_enable, cfg_capture_fall, cfg_idle_high, cfg_clk_delay, cfg_frame_pol, cfg_frame_edge;
  logic [7:0] cfg_clk_div;
  logic [5:0] cfg_tx_wlen, cfg_tx_dlen, cfg_rx_dlen;
  logic [1:0] cfg_tx_fmt, cfg_rx_fmt;
  logic [3:0] cfg_tx_thr, cfg_rx_thr;
  logic eng_busy = 0, eng_tx_done = 0, tx_valid, tx_ready = 0, rx_valid = 0, irq;
  logic [31:0] tx_word, rx_word = 0;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  spi_regfile dut (.*);

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rx_in(input logic [31:0] w);
    @(negedge clk); rx_valid = 1; rx_word = w;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic tx_take(output logic v, output logic [31:0] w);
    @(negedge clk); #1 v = tx_valid; w = tx_word; tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h14, d); chk(d, 32'h20, "R1 status");
    rd(6'h00, d); chk(d, 0, "R1 ctl");
    chk({tx_valid, irq, cfg_clk_div}, 0, "R1 outputs");
  endtask

  task automatic t_config;
    logic [31:0] d;
    logic [5:0] a [7] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h18, 6'h20};
    logic [31:0] e [7] = '{32'h1, 32'h70FF, 32'h3FFF, 32'hFF, 32'hC000, 32'h19, 32'h0F0F};
    for (int i = 0; i < 7; i++) begin
      wr(a[i], 32'hFFFF_FFFF); rd(a[i], d); chk(d, e[i], "R2 readback");
    end
    chk({cfg_clk_div, cfg_capture_fall, cfg_idle_high, cfg_clk_delay, cfg_frame_pol, cfg_frame_edge},
        {8'hFF, 5'b11111}, "R2 clock/frame fields");
    chk({cfg_tx_wlen, cfg_tx_fmt, cfg_tx_dlen, cfg_rx_fmt, cfg_rx_dlen, cfg_tx_thr, cfg_rx_thr},
        {6'h3F, 2'h3, 6'h3F, 2'h3, 6'h3F, 4'hF, 4'hF}, "R2 word/threshold fields");
    for (int i = 0; i < 7; i++) wr(a[i], 0);
  endtask

  task automatic t_tx_order;
    logic v; logic [31:0] w;
    for (int i = 0; i < 3; i++) wr(6'h24, 32'hC0DE_0000 + i);
    #1 chk(tx_valid, 0, "R3 held while disabled");
    wr(6'h00, 1);
    for (int i = 0; i < 3; i++) begin
      tx_take(v, w); chk({v, w}, {1'b1, 32'hC0DE_0000 + i}, "R3 order");
    end
    #1 chk(tx_valid, 0, "R3 empty after pops");
    wr(6'h00, 0);
  endtask

  task automatic t_tx_full;
    logic [31:0] d; logic v; logic [31:0] w;
    for (int i = 0; i < 9; i++) wr(6'h24, 32'hA0 + i);
    rd(6'h14, d); chk(d[5], 0, "R4 full status");
    wr(6'h00, 1);
    for (int i = 0; i < 8; i++) begin
      tx_take(v, w); chk({v, w}, {1'b1, 32'hA0 + i}, "R4 drained");
    end
    #1 chk(tx_valid, 0, "R4 ninth write dropped");
    wr(6'h00, 0);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    for (int i = 0; i < 3; i++) rx_in(32'h5500 + i);
    rd(6'h14, d); chk(d, 32'h21, "R6 rx not empty");
    for (int i = 0; i < 3; i++) begin
      rd(6'h24, d); chk(d, 32'h5500 + i, "R5 rx order");
    end
    rd(6'h24, d); chk(d, 0, "R5 empty read");
    rd(6'h14, d); chk(d, 32'h20, "R5 empty read no change");
    eng_busy = 1;
    rd(6'h14, d); chk(d, 32'hA0, "R6 busy");
    eng_busy = 0;
    wr(6'h1C, 32'h19);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    wr(6'h24, 1); wr(6'h24, 2); rx_in(7); rx_in(8);
    wr(6'h20, 32'h1A14);
    rd(6'h20, d); chk(d, 32'h0A04, "R7 flush reads 0, thresholds kept");
    rd(6'h14, d); chk(d, 32'h20, "R7 both FIFOs empty");
    wr(6'h00, 1); #1 chk(tx_valid, 0, "R7 tx empty");
    wr(6'h00, 0); wr(6'h20, 0); wr(6'h1C, 32'h19);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    for (int i = 0; i < 9; i++) rx_in(32'hB0 + i);
    rd(6'h1C, d); chk(d, 32'h09, "R8 overrun flag");
    for (int i = 0; i < 8; i++) begin
      rd(6'h24, d); chk(d, 32'hB0 + i, "R8 kept words");
    end
    rd(6'h24, d); chk(d, 0, "R8 overflow word discarded");
  endtask

  task automatic t_flags;
    logic [31:0] d;
    wr(6'h1C, 0); rd(6'h1C, d); chk(d, 32'h09, "R9 zero write no effect");
    wr(6'h1C, 32'h08); rd(6'h1C, d); chk(d, 32'h01, "R9 clear rx-complete");
    @(negedge clk); eng_tx_done = 1; @(negedge clk); eng_tx_done = 0;
    rd(6'h1C, d); chk(d, 32'h11, "R9 tx-complete set");
    wr(6'h1C, 32'h11); rd(6'h1C, d); chk(d, 0, "R9 clear all");
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 6'h1C; bus_wdata = 32'h10; eng_tx_done = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; eng_tx_done = 0;
    rd(6'h1C, d); chk(d, 32'h10, "R9 set wins");
    wr(6'h1C, 32'h19);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(6'h18, 0); rx_in(32'h33);
    #1 chk(irq, 0, "R10 masked");
    wr(6'h18, 32'h08); #1 chk(irq, 1, "R10 enabled flag");
    wr(6'h18, 32'h11); #1 chk(irq, 0, "R10 other enables");
    rd(6'h24, d);
    wr(6'h18, 32'h08); wr(6'h1C, 32'h08); #1 chk(irq, 0, "R10 cleared");
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_config;
    t_tx_order;
    t_tx_full;
    t_rx;
    t_flush;
    t_overrun;
    t_flags;
    t_irq;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule